// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block is the device-side consumer of a circular command buffer that lives in host memory. Host software places 32-bit command words into consecutive ring slots and then moves a write pointer forward through the register port. Whenever the engine is running and its own read pointer differs from the write pointer, it computes the address of the next slot, reads that word through a single-outstanding memory request/response port, and presents it on a valid/ready command output. The read pointer moves only once the word has been taken.

Both pointers name the slot that was most recently written or consumed, so the slot to handle next is always (pointer + 1) modulo the ring size. Straight after a pointer reset, the first slot fetched is index 1 and slot 0 is reached only after wrap. The ring holds 2, 16 or 256 entries, chosen by a select field that may only pick a size the capability mask allows. Software resets the read pointer with a handshake: it sets a reset bit and waits for it to read back as 1, then clears it and waits for it to read back as 0. It zeroes the write pointer before setting the run bit.

Top module: `cmdring_fetch`

Register map (word index on `reg_addr`, combinational read on `reg_rdata`):
- 0 control: bit 0 run.
- 1 ring size: bits 1:0 select (0 = 2, 1 = 16, 2 = 256 entries), bits 6:4 capability mask (bit 4 = 2, bit 5 = 16, bit 6 = 256 supported), read-only.
- 2 base low: bits 31:7 stored, bits 6:0 read 0 (128-byte alignment).
- 3 base high: upper address bits, stored only when 64-bit addressing is enabled.
- 4 read pointer: bits 7:0 pointer (read-only), bit 15 reset bit.
- 5 write pointer: bits 7:0.

## Requirements
- R1: After reset, run, read pointer, write pointer, reset bit, `mem_req` and `cmd_valid` are 0, base reads 0, and the size select holds the largest size whose capability bit is set (default mask 3'b111 gives select 2, so register 1 reads 0x72).
- R2: A write to register 1 while stopped takes the new select only if it is 0, 1 or 2 and its capability bit is set; otherwise the select is unchanged.
- R3: Base low bits 6:0 always read 0; base high is stored when 64-bit addressing is enabled; writes to size select and to either base register are ignored while run is 1.
- R4: The fetch address is base + 4 × ((read pointer + 1) mod ring size), so the first fetch after a pointer reset targets slot 1.
- R5: A new memory request starts only while run is 1 and read pointer differs from write pointer; after run is cleared no further request starts and the read pointer stays put.
- R6: The read pointer advances by one slot only on a cycle where `cmd_valid` and `cmd_ready` are both 1; while `cmd_ready` is 0, `cmd_valid` and `cmd_data` hold steady.
- R7: `cmd_data` carries the `mem_rdata` word returned for that slot's request.
- R8: Writing register 4 with bit 15 set clears the read pointer and bit 15 reads 1 from the next cycle; writing it with bit 15 clear makes bit 15 read 0; no fetch starts while the bit is set.
- R9: While `mem_req` is 1 and `mem_req_ready` is 0, `mem_req` stays 1 and `mem_addr` is unchanged.
- R10: A write-pointer value is masked to the pointer width of the selected size (7:0 for 256, 3:0 for 16, bit 0 for 2), and pointers wrap from the last slot back to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | ADDR_W | Byte address of the slot to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| cmd_valid | output | 1 | Command word valid |
| cmd_ready | input | 1 | Consumer accepts the command word |
| cmd_data | output | 32 | Command word |

## Verification
A wrong read pointer shows at the ports within one fetch: the next `mem_addr` points at the wrong slot, or the register 4 readback disagrees after the next command is accepted. A lost wrap or mask shows as an address outside the ring on the fetch that crosses the last slot. A broken hold under back-pressure shows in the same cycle as a dropped or changed command word, and a run bit that is ignored shows as an extra memory request within a few cycles of the write-pointer update.

// File: rtl/cmdring_pkg.sv
// Package: shared constants, types and helpers for the command ring fetch engine.
// Assumes pointers never exceed 8 bits (largest ring is 256 entries).
package cmdring_pkg;
    localparam int PTR_W = 8;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_SIZE  = 3'd1;
    localparam logic [2:0] A_BLO   = 3'd2;
    localparam logic [2:0] A_BHI   = 3'd3;
    localparam logic [2:0] A_RPTR  = 3'd4;
    localparam logic [2:0] A_WPTR  = 3'd5;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_OUT} fetch_st_t;

    // Pointer mask for a size select code.
    function automatic logic [PTR_W-1:0] size_mask(input logic [1:0] sel);
        case (sel)
            2'd0:    size_mask = 8'h01;
            2'd1:    size_mask = 8'h0F;
            default: size_mask = 8'hFF;
        endcase
    endfunction

    // True when the capability mask allows a select code.
    function automatic logic cap_has(input logic [2:0] cap, input logic [1:0] sel);
        case (sel)
            2'd0:    cap_has = cap[0];
            2'd1:    cap_has = cap[1];
            2'd2:    cap_has = cap[2];
            default: cap_has = 1'b0;
        endcase
    endfunction

    // Largest size allowed by the capability mask.
    function automatic logic [1:0] pick_size(input logic [2:0] cap);
        if (cap[2])      pick_size = 2'd2;
        else if (cap[1]) pick_size = 2'd1;
        else             pick_size = 2'd0;
    endfunction
endpackage

// File: rtl/cmdring_regs.sv
// Register file: run control, size select, base address, pointers and the
// read-pointer reset bit. Assumes a single write port and combinational reads.
module cmdring_regs
    import cmdring_pkg::*;
#(
    parameter int         ADDR_W   = 64,
    parameter logic [2:0] CAP_MASK = 3'b111,
    parameter bit         ADDR64   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              adv,
    input  logic [PTR_W-1:0]  adv_idx,
    output logic              run_o,
    output logic              hold_o,
    output logic [PTR_W-1:0]  rp_o,
    output logic [PTR_W-1:0]  wp_o,
    output logic [PTR_W-1:0]  mask_o,
    output logic [ADDR_W-1:0] base_o
);
    localparam int HI_W = ADDR_W - 32;

    logic              run_q, rst_q;
    logic [1:0]        sel_q;
    logic [24:0]       blo_q;
    logic [HI_W-1:0]   bhi_q;
    logic [PTR_W-1:0]  rp_q, wp_q;

    logic wr_ctrl, wr_size, wr_blo, wr_bhi, wr_rptr, wr_wptr, rp_clr;
    assign wr_ctrl = reg_we && reg_addr == A_CTRL;
    assign wr_size = reg_we && reg_addr == A_SIZE;
    assign wr_blo  = reg_we && reg_addr == A_BLO;
    assign wr_bhi  = reg_we && reg_addr == A_BHI;
    assign wr_rptr = reg_we && reg_addr == A_RPTR;
    assign wr_wptr = reg_we && reg_addr == A_WPTR;
    assign rp_clr  = wr_rptr && reg_wdata[15];

    // Run bit and read-pointer reset bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            if (wr_ctrl) run_q <= reg_wdata[0];
            if (wr_rptr) rst_q <= reg_wdata[15];
        end
    end

    // Size select and low base; frozen while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= pick_size(CAP_MASK);
            blo_q <= '0;
        end else if (!run_q) begin
            if (wr_size && cap_has(CAP_MASK, reg_wdata[1:0])) sel_q <= reg_wdata[1:0];
            if (wr_blo) blo_q <= reg_wdata[31:7];
        end
    end

    generate
        if (ADDR64) begin : g_hi
            // Upper base bits, stored only while stopped.
            always_ff @(posedge clk) begin
                if (!rst_n)                bhi_q <= '0;
                else if (!run_q && wr_bhi) bhi_q <= reg_wdata[HI_W-1:0];
            end
        end else begin : g_nohi
            assign bhi_q = '0;
        end
    endgenerate

    // Read and write pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_q <= '0;
            wp_q <= '0;
        end else begin
            if (rp_clr)   rp_q <= '0;
            else if (adv) rp_q <= adv_idx;
            if (wr_wptr)  wp_q <= reg_wdata[PTR_W-1:0] & size_mask(sel_q);
        end
    end

    // Register read mux.
    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {31'd0, run_q};
            A_SIZE:  reg_rdata = {25'd0, CAP_MASK, 2'd0, sel_q};
            A_BLO:   reg_rdata = {blo_q, 7'd0};
            A_BHI:   reg_rdata = 32'(bhi_q);
            A_RPTR:  reg_rdata = {16'd0, rst_q, 7'd0, rp_q};
            A_WPTR:  reg_rdata = {24'd0, wp_q};
            default: reg_rdata = 32'd0;
        endcase
    end

    assign run_o  = run_q;
    assign hold_o = rst_q;
    assign rp_o   = rp_q;
    assign wp_o   = wp_q;
    assign mask_o = size_mask(sel_q);
    assign base_o = {bhi_q, blo_q, 7'd0};

    // R6: read pointer moves only on an accept or a pointer reset.
    p_rp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !rp_clr) |=> $stable(rp_q));
    // R2: the select always names a supported size.
    p_sel_supported_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_has(CAP_MASK, sel_q));
    // R3: configuration frozen while running.
    p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> $stable(sel_q) && $stable(base_o));
    // R8: reset bit reads back with a cleared pointer.
    p_rst_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rp_clr |=> rst_q && rp_q == '0);
endmodule

// File: rtl/cmdring_fetcher.sv
// Fetch sequencer: one outstanding read at a time; issues a request for the
// slot after the read pointer, captures the word, holds it on the command
// output until accepted, then reports the new pointer value.
module cmdring_fetcher
    import cmdring_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              hold,
    input  logic [PTR_W-1:0]  rp,
    input  logic [PTR_W-1:0]  wp,
    input  logic [PTR_W-1:0]  mask,
    input  logic [ADDR_W-1:0] base,
    output logic              mem_req,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [31:0]       cmd_data,
    output logic              adv,
    output logic [PTR_W-1:0]  adv_idx
);
    fetch_st_t         st_q;
    logic [PTR_W-1:0]  idx_q, nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       data_q;
    logic              pending;

    assign nxt     = (rp + 1'b1) & mask;
    assign pending = (rp & mask) != (wp & mask);

    // State machine and captured request/response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (run && !hold && pending) begin
                    idx_q  <= nxt;
                    addr_q <= base + {{(ADDR_W-PTR_W-2){1'b0}}, nxt, 2'b00};
                    st_q   <= ST_REQ;
                end
                ST_REQ:  if (mem_req_ready) st_q <= ST_WAIT;
                ST_WAIT: if (mem_rvalid) begin
                    data_q <= mem_rdata;
                    st_q   <= ST_OUT;
                end
                default: if (cmd_ready) st_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_req   = st_q == ST_REQ;
    assign mem_addr  = addr_q;
    assign cmd_valid = st_q == ST_OUT;
    assign cmd_data  = data_q;
    assign adv       = cmd_valid && cmd_ready;
    assign adv_idx   = idx_q;

    // R9: request held with a stable address until taken.
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_req_ready) |=> mem_req && $stable(mem_addr));
    // R6: command held stable under back-pressure.
    p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_data));
    // R5: a new request only follows a cycle with run set.
    p_start_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(run));
endmodule

// File: rtl/cmdring_fetch.sv
// Top: command ring fetch engine. Joins the register file and the fetch
// sequencer. Assumes the memory returns exactly one response per request.
module cmdring_fetch
    import cmdring_pkg::*;
#(
    parameter int         ADDR_W   = 64,
    parameter logic [2:0] CAP_MASK = 3'b111,
    parameter bit         ADDR64   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [31:0]       cmd_data
);
    logic              run, hold, adv;
    logic [PTR_W-1:0]  rp, wp, mask, adv_idx;
    logic [ADDR_W-1:0] base;

    cmdring_regs #(.ADDR_W(ADDR_W), .CAP_MASK(CAP_MASK), .ADDR64(ADDR64)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adv(adv), .adv_idx(adv_idx),
        .run_o(run), .hold_o(hold), .rp_o(rp), .wp_o(wp), .mask_o(mask), .base_o(base)
    );

    cmdring_fetcher #(.ADDR_W(ADDR_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .run(run), .hold(hold), .rp(rp), .wp(wp),
        .mask(mask), .base(base), .mem_req(mem_req), .mem_req_ready(mem_req_ready),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .adv(adv), .adv_idx(adv_idx)
    );
endmodule

// File: tb/sim_cmdring_fetch.sv
`timescale 1ns/1ps
// Directed bench: memory model answers one cycle after each request; a sink
// logs accepted commands; each task checks its own scenario.
module sim_cmdring_fetch;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0, reg_rdata;
    logic        mem_req, mem_req_ready = 1'b1, mem_rvalid = 1'b0;
    logic [63:0] mem_addr;
    logic [31:0] mem_rdata = 32'd0;
    logic        cmd_valid, cmd_ready = 1'b1;
    logic [31:0] cmd_data;

    int          n_chk = 0, n_bad = 0;
    bit          stall = 1'b0, done = 1'b0;
    int          req_n = 0, cmd_n = 0;
    logic [63:0] req_log [0:63];
    logic [31:0] cmd_log [0:63];

    localparam logic [63:0] BASE = 64'h0000_0000_1000_0F80;

    cmdring_fetch u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_req_ready(mem_req_ready), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] word_at(input logic [63:0] a);
        return a[31:0] ^ a[63:32] ^ 32'hA5A5_0000;
    endfunction

    // Memory model: one cycle from accepted request to response.
    initial begin
        bit pend = 1'b0;
        logic [63:0] pa = '0;
        forever begin
            @(negedge clk); #1;
            mem_req_ready = !stall;
            if (pend) begin mem_rvalid = 1'b1; mem_rdata = word_at(pa); pend = 1'b0; end
            else mem_rvalid = 1'b0;
            if (mem_req && mem_req_ready) begin
                pa = mem_addr; pend = 1'b1;
                if (req_n < 64) req_log[req_n] = mem_addr;
                req_n++;
            end
        end
    end

    // Command sink log.
    initial begin
        forever begin
            @(negedge clk); #1;
            if (cmd_valid && cmd_ready) begin
                if (cmd_n < 64) cmd_log[cmd_n] = cmd_data;
                cmd_n++;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #2 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pointer reset handshake, write pointer to 0.
    task automatic ptr_reset();
        logic [31:0] d;
        wr(3'd4, 32'h8000);
        rd(3'd4, d); chk("R8 reset bit reads 1, pointer 0", d, 32'h8000);
        wr(3'd4, 32'h0);
        rd(3'd4, d); chk("R8 reset bit reads 0", d, 32'h0);
        wr(3'd5, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(3'd0, d); chk("R1 run", d, 0);
        rd(3'd1, d); chk("R1 size reg", d, 32'h72);
        rd(3'd2, d); chk("R1 base low", d, 0);
        rd(3'd4, d); chk("R1 read ptr", d, 0);
        rd(3'd5, d); chk("R1 write ptr", d, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 cmd_valid", cmd_valid, 0);
    endtask

    task automatic t_config();
        logic [31:0] d;
        wr(3'd1, 32'h1); rd(3'd1, d); chk("R2 select 16 entries", d, 32'h71);
        wr(3'd1, 32'h3); rd(3'd1, d); chk("R2 illegal select ignored", d, 32'h71);
        wr(3'd2, 32'h1000_0FFF); rd(3'd2, d); chk("R3 low bits read 0", d, 32'h1000_0F80);
        wr(3'd3, 32'h12); rd(3'd3, d); chk("R3 base high stored", d, 32'h12);
        wr(3'd3, 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        ptr_reset();
        wr(3'd0, 32'h1);
        wr(3'd5, 32'h3);
        idle(40);
        chk("R5 three requests", req_n, 3);
        for (int i = 0; i < 3; i++) begin
            chk("R4 slot address", req_log[i], BASE + 64'(4 * (i + 1)));
            chk("R7 command word", cmd_log[i], word_at(BASE + 64'(4 * (i + 1))));
        end
        rd(3'd4, d); chk("R6 pointer after three", d, 3);
    endtask

    task automatic t_backpressure();
        logic [31:0] d;
        cmd_ready = 1'b0;
        wr(3'd5, 32'h5);
        idle(15);
        chk("R6 valid held", cmd_valid, 1);
        chk("R6 data held", cmd_data, word_at(BASE + 16));
        rd(3'd4, d); chk("R6 pointer waits for accept", d, 3);
        idle(5);
        chk("R6 data still held", cmd_data, word_at(BASE + 16));
        cmd_ready = 1'b1;
        idle(30);
        rd(3'd4, d); chk("R6 pointer after accept", d, 5);
        chk("R6 commands accepted", cmd_n, 5);
    endtask

    task automatic t_frozen();
        logic [31:0] d;
        wr(3'd1, 32'h0); rd(3'd1, d); chk("R3 select frozen while running", d, 32'h71);
        wr(3'd2, 32'h2000_0000); rd(3'd2, d); chk("R3 base frozen while running", d, 32'h1000_0F80);
    endtask

    task automatic t_stop();
        logic [31:0] d;
        wr(3'd0, 32'h0);
        wr(3'd5, 32'h8);
        idle(30);
        chk("R5 no request when stopped", req_n, 5);
        rd(3'd4, d); chk("R5 pointer still when stopped", d, 5);
        wr(3'd0, 32'h1);
        idle(50);
        chk("R5 resumed requests", req_n, 8);
        rd(3'd4, d); chk("R5 pointer after resume", d, 8);
    endtask

    task automatic t_reqstall();
        logic [31:0] d;
        stall = 1'b1;
        wr(3'd5, 32'h9);
        idle(8);
        chk("R9 request held", mem_req, 1);
        chk("R9 address held", mem_addr, BASE + 36);
        chk("R9 no accept while stalled", req_n, 8);
        stall = 1'b0;
        idle(20);
        chk("R7 word after stall", cmd_log[8], word_at(BASE + 36));
        rd(3'd4, d); chk("R9 pointer after stall", d, 9);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        ptr_reset();
        wr(3'd0, 32'h1);
        wr(3'd5, 32'hFF);
        rd(3'd5, d); chk("R10 write ptr masked", d, 1);
        idle(20);
        chk("R10 slot 1 first", req_log[9], BASE + 4);
        wr(3'd5, 32'h0);
        idle(20);
        chk("R10 wrap to slot 0", req_log[10], BASE);
        rd(3'd4, d); chk("R10 pointer wrapped", d, 0);
    endtask

    task automatic t_high();
        wr(3'd0, 32'h0);
        wr(3'd3, 32'h5);
        wr(3'd1, 32'h1);
        ptr_reset();
        wr(3'd0, 32'h1);
        wr(3'd5, 32'h1);
        idle(20);
        chk("R3 upper address bits used", req_log[11], {32'h5, BASE[31:0]} + 4);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_config();
        t_basic();
        t_backpressure();
        t_frozen();
        t_stop();
        t_reqstall();
        t_wrap();
        t_high();
        finish_run();
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule